// File: doc/BRIEF.md
# Serial Boot-Mode Configuration Loader

This block runs once after a cold reset. It waits for the power-good input. It then produces a slow mode clock by dividing the system clock and shifts in a serial configuration stream one bit per mode-clock period, least significant position first. When the whole stream has arrived, it decodes the captured bits into registered processor mode fields. These fields are the bus data pattern, the pipeline-to-bus clock ratio, byte order, non-block write mode, timer-interrupt disable, bus width, output drive level, write address-to-data delay and fast-multiply enable.

The decoded fields and a valid flag change together in a single cycle. After that they do not change until the next cold reset. A configuration-error flag reports any reserved encoding and any reserved bit that arrives set. The block holds the core reset output low through loading and then for a fixed number of further system-clock cycles before it releases it.

Top module: `bootcfg_loader`

## Requirements
- R1: While loading, `modeClk` has a period of DIV_RATIO system clocks (default 256). It is low for the first half of each period and high for the second half. Outside loading it stays low.
- R2: Each stream bit is sampled on the system clock edge where `modeClk` rises. `modeIn` must have been stable for at least 4 system clocks before that edge.
- R3: Loading starts only after `powerGood` is high. The stream is STREAM_LEN bits long (default 256), and stream bit 0 arrives first.
- R4: `xmitPattern` equals stream bits 4:1, with bit 4 as the MSB.
- R5: `clkRatio` equals stream bits 7:5 plus 2, which gives 2 to 8. Code 7 yields 0.
- R6: The following single-bit and raw fields are taken directly from the stream:
  - `bigEndian` = bit 8.
  - `writeMode` = bits 10:9.
  - `timerIntOff` = bit 11.
  - `bus32` = bit 12.
  - `wrDelay` = bits 17:15.
  - `fastMulEn` = the inverse of bit 19.
- R7: `driveLevel` is decoded from stream bits 14:13 as follows: 01 gives 0 (50%), 00 gives 1 (67%), 11 gives 2 (83%) and 10 gives 3 (100%).
- R8: `cfgErr` is set if any of these holds:
  - bit 0 is 1;
  - bits 4:1 are 9 or more;
  - bits 7:5 are 7;
  - bits 10:9 are 01;
  - bit 18 is 1;
  - any bit from 20 to STREAM_LEN-1 is 1.
- R9: The fields, `cfgErr` and `cfgValid` update together in one cycle after the full stream is captured, and are zero before that. Afterwards, changes on `modeIn` or `powerGood` leave them unchanged until cold reset.
- R10: `coreResetN` is low until exactly HOLD_CYC system clocks (default 64) after `cfgValid` rises, then goes high.
- R11: `coldResetN` low clears the block at once, including a load in progress, and every output goes to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| coldResetN | input | 1 | Asynchronous active-low cold reset |
| powerGood | input | 1 | Supply-stable indication; starts loading |
| modeIn | input | 1 | Serial configuration data |
| modeClk | output | 1 | Divided mode clock for the serial source |
| coreResetN | output | 1 | Active-low reset released to the core |
| cfgValid | output | 1 | Decoded fields are valid |
| cfgErr | output | 1 | Reserved value or bit received |
| xmitPattern | output | 4 | Bus data pattern select |
| clkRatio | output | 4 | Pipeline-to-bus clock ratio (0 if reserved) |
| bigEndian | output | 1 | Big-endian byte order |
| writeMode | output | 2 | Non-block write mode code |
| timerIntOff | output | 1 | Timer interrupt disabled |
| bus32 | output | 1 | 32-bit system bus selected |
| driveLevel | output | 2 | Output drive level, 0 = weakest |
| wrDelay | output | 3 | Write address-to-data delay in bus cycles |
| fastMulEn | output | 1 | Fast multiply enabled |

## Verification
The assertions assume that the serial source changes `modeIn` only after a falling edge of `modeClk`, so that the 4-cycle setup check on each sample holds. They also assume cold reset is the only way the stream restarts. The stimulus meets this by updating the data one system clock after each `modeClk` fall. It raises `powerGood` only after placing bit 0. The bench mixes seeded random streams that keep every field legal with directed streams that each break one reserved rule. It then changes the inputs after loading to show that the fields stay put.

// File: rtl/bootcfg_pkg.sv
package bootcfg_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic sample;   // capture modeIn this cycle
    logic commit;   // decode the captured stream this cycle
  } ctrlStrb_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_COMMIT,
    ST_HOLD,
    ST_RUN
  } loadState_t;

  // stream positions that carry named fields (0..19)
  localparam int CAP_BITS = 20;
  localparam int CAP_W    = $clog2(CAP_BITS + 1);
  localparam int SETUP_MIN = 4;

endpackage

// File: rtl/bootcfg_ctrl.sv
module bootcfg_ctrl
  import bootcfg_pkg::*;
#(
  parameter int DIV_RATIO  = 256,
  parameter int STREAM_LEN = 256,
  parameter int HOLD_CYC   = 64
) (
  input  logic      clk,
  input  logic      coldResetN,
  input  logic      powerGood,
  output ctrlStrb_t strb,
  output logic      modeClk,
  output logic      cfgValid,
  output logic      coreResetN
);

  localparam int DIV_W  = $clog2(DIV_RATIO);
  localparam int HALF   = DIV_RATIO / 2;
  localparam int LEN_W  = $clog2(STREAM_LEN + 1);
  localparam int HOLD_W = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;

  loadState_t        state;
  logic [DIV_W-1:0]  divCnt;
  logic [LEN_W-1:0]  bitCnt;
  logic [HOLD_W-1:0] holdCnt;
  logic              divWrap;

  assign divWrap     = (divCnt == DIV_W'(DIV_RATIO - 1));
  assign strb.sample = (state == ST_LOAD) && (divCnt == DIV_W'(HALF - 1))
                       && (bitCnt != LEN_W'(STREAM_LEN));
  assign strb.commit = (state == ST_COMMIT);
  assign modeClk     = (state == ST_LOAD) && (divCnt >= DIV_W'(HALF));
  assign cfgValid    = (state == ST_HOLD) || (state == ST_RUN);
  assign coreResetN  = (state == ST_RUN);

  always_ff @(posedge clk or negedge coldResetN) begin
    if (!coldResetN) begin
      state   <= ST_IDLE;
      divCnt  <= '0;
      bitCnt  <= '0;
      holdCnt <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          divCnt <= '0;
          bitCnt <= '0;
          if (powerGood) state <= ST_LOAD;
        end
        ST_LOAD: begin
          divCnt <= divWrap ? '0 : divCnt + 1'b1;
          if (strb.sample) bitCnt <= bitCnt + 1'b1;
          if (divWrap && bitCnt == LEN_W'(STREAM_LEN)) state <= ST_COMMIT;
        end
        ST_COMMIT: begin
          holdCnt <= '0;
          state   <= ST_HOLD;
        end
        ST_HOLD: begin
          holdCnt <= holdCnt + 1'b1;
          if (holdCnt == HOLD_W'(HOLD_CYC - 1)) state <= ST_RUN;
        end
        default: state <= ST_RUN;
      endcase
    end
  end

  // R2: every sample coincides with a rising mode clock
  p_sample_on_rise_r2: assert property (@(posedge clk) disable iff (!coldResetN)
    strb.sample |=> $rose(modeClk));

  // R3: decode only after the full stream length has been counted
  p_full_stream_r3: assert property (@(posedge clk) disable iff (!coldResetN)
    strb.commit |-> (bitCnt == LEN_W'(STREAM_LEN)));

endmodule

// File: rtl/bootcfg_datapath.sv
module bootcfg_datapath
  import bootcfg_pkg::*;
(
  input  logic      clk,
  input  logic      coldResetN,
  input  logic      modeIn,
  input  ctrlStrb_t strb,
  output logic      cfgErr,
  output logic [3:0] xmitPattern,
  output logic [3:0] clkRatio,
  output logic      bigEndian,
  output logic [1:0] writeMode,
  output logic      timerIntOff,
  output logic      bus32,
  output logic [1:0] driveLevel,
  output logic [2:0] wrDelay,
  output logic      fastMulEn
);

  logic [CAP_BITS-1:0] cap;
  logic [CAP_W-1:0]    capCnt;
  logic                hiSeen;
  logic                prevIn;
  logic [3:0]          stableCnt;
  logic                errNow;
  logic [1:0]          driveDec;
  logic [3:0]          ratioDec;

  always_ff @(posedge clk or negedge coldResetN) begin
    if (!coldResetN) begin
      cap    <= '0;
      capCnt <= '0;
      hiSeen <= 1'b0;
    end else if (strb.sample) begin
      if (capCnt < CAP_W'(CAP_BITS)) begin
        cap[capCnt] <= modeIn;
        capCnt      <= capCnt + 1'b1;
      end else begin
        hiSeen <= hiSeen | modeIn;
      end
    end
  end

  // setup tracking on the serial input
  always_ff @(posedge clk or negedge coldResetN) begin
    if (!coldResetN) begin
      prevIn    <= 1'b0;
      stableCnt <= '0;
    end else begin
      prevIn <= modeIn;
      if (modeIn != prevIn) stableCnt <= '0;
      else if (stableCnt != 4'hF) stableCnt <= stableCnt + 1'b1;
    end
  end

  always_comb begin
    case (cap[14:13])
      2'b01:   driveDec = 2'd0;
      2'b00:   driveDec = 2'd1;
      2'b11:   driveDec = 2'd2;
      default: driveDec = 2'd3;
    endcase
    ratioDec = (cap[7:5] == 3'd7) ? 4'd0 : ({1'b0, cap[7:5]} + 4'd2);
    errNow = cap[0] | (cap[4:1] >= 4'd9) | (cap[7:5] == 3'd7)
           | (cap[10:9] == 2'b01) | cap[18] | hiSeen;
  end

  always_ff @(posedge clk or negedge coldResetN) begin
    if (!coldResetN) begin
      cfgErr      <= 1'b0;
      xmitPattern <= '0;
      clkRatio    <= '0;
      bigEndian   <= 1'b0;
      writeMode   <= '0;
      timerIntOff <= 1'b0;
      bus32       <= 1'b0;
      driveLevel  <= '0;
      wrDelay     <= '0;
      fastMulEn   <= 1'b0;
    end else if (strb.commit) begin
      cfgErr      <= errNow;
      xmitPattern <= cap[4:1];
      clkRatio    <= ratioDec;
      bigEndian   <= cap[8];
      writeMode   <= cap[10:9];
      timerIntOff <= cap[11];
      bus32       <= cap[12];
      driveLevel  <= driveDec;
      wrDelay     <= cap[17:15];
      fastMulEn   <= ~cap[19];
    end
  end

  // R2: input assumption, data held steady before each sample
  p_setup_r2: assert property (@(posedge clk) disable iff (!coldResetN)
    strb.sample |-> (stableCnt >= 4'(SETUP_MIN)));

  // R8: a set reserved bit 0 must surface as an error
  p_err_bit0_r8: assert property (@(posedge clk) disable iff (!coldResetN)
    (strb.commit && cap[0]) |=> cfgErr);

endmodule

// File: rtl/bootcfg_loader.sv
module bootcfg_loader
  import bootcfg_pkg::*;
#(
  parameter int DIV_RATIO  = 256,
  parameter int STREAM_LEN = 256,
  parameter int HOLD_CYC   = 64
) (
  input  logic       clk,
  input  logic       coldResetN,
  input  logic       powerGood,
  input  logic       modeIn,
  output logic       modeClk,
  output logic       coreResetN,
  output logic       cfgValid,
  output logic       cfgErr,
  output logic [3:0] xmitPattern,
  output logic [3:0] clkRatio,
  output logic       bigEndian,
  output logic [1:0] writeMode,
  output logic       timerIntOff,
  output logic       bus32,
  output logic [1:0] driveLevel,
  output logic [2:0] wrDelay,
  output logic       fastMulEn
);

  localparam int AGE_W = $clog2(HOLD_CYC + 1);

  ctrlStrb_t strb;

  bootcfg_ctrl #(
    .DIV_RATIO (DIV_RATIO),
    .STREAM_LEN(STREAM_LEN),
    .HOLD_CYC  (HOLD_CYC)
  ) u_ctrl (
    .clk       (clk),
    .coldResetN(coldResetN),
    .powerGood (powerGood),
    .strb      (strb),
    .modeClk   (modeClk),
    .cfgValid  (cfgValid),
    .coreResetN(coreResetN)
  );

  bootcfg_datapath u_dp (
    .clk        (clk),
    .coldResetN (coldResetN),
    .modeIn     (modeIn),
    .strb       (strb),
    .cfgErr     (cfgErr),
    .xmitPattern(xmitPattern),
    .clkRatio   (clkRatio),
    .bigEndian  (bigEndian),
    .writeMode  (writeMode),
    .timerIntOff(timerIntOff),
    .bus32      (bus32),
    .driveLevel (driveLevel),
    .wrDelay    (wrDelay),
    .fastMulEn  (fastMulEn)
  );

  // cycles since cfgValid rose, saturating (assertion support)
  logic [AGE_W-1:0] validAge;
  always_ff @(posedge clk or negedge coldResetN) begin
    if (!coldResetN) validAge <= '0;
    else if (cfgValid && validAge != AGE_W'(HOLD_CYC)) validAge <= validAge + 1'b1;
  end

  // R10: core reset released exactly HOLD_CYC cycles after valid
  p_hold_window_r10: assert property (@(posedge clk) disable iff (!coldResetN)
    $rose(coreResetN) |-> (validAge == AGE_W'(HOLD_CYC)));

  p_release_needs_cfg_r10: assert property (@(posedge clk) disable iff (!coldResetN)
    coreResetN |-> cfgValid);

  // R9: decoded fields frozen once valid
  p_fields_frozen_r9: assert property (@(posedge clk) disable iff (!coldResetN)
    (cfgValid && $past(cfgValid)) |-> $stable({cfgErr, xmitPattern, clkRatio, bigEndian,
      writeMode, timerIntOff, bus32, driveLevel, wrDelay, fastMulEn}));

endmodule

// File: tb/bootcfg_loader_bench.sv
`timescale 1ns/1ps
module bootcfg_loader_bench;

  localparam int DIV  = 16;
  localparam int LEN  = 32;
  localparam int HOLD = 64;

  logic clk = 1'b0;
  logic coldResetN = 1'b0;
  logic powerGood = 1'b0;
  logic modeIn = 1'b0;
  logic modeClk, coreResetN, cfgValid, cfgErr;
  logic [3:0] xmitPattern, clkRatio;
  logic bigEndian, timerIntOff, bus32, fastMulEn;
  logic [1:0] writeMode, driveLevel;
  logic [2:0] wrDelay;

  int testsRun = 0;
  int testsFail = 0;

  always #5 clk = ~clk;

  bootcfg_loader #(.DIV_RATIO(DIV), .STREAM_LEN(LEN), .HOLD_CYC(HOLD)) u_bootcfg_loader (
    .clk(clk), .coldResetN(coldResetN), .powerGood(powerGood), .modeIn(modeIn),
    .modeClk(modeClk), .coreResetN(coreResetN), .cfgValid(cfgValid), .cfgErr(cfgErr),
    .xmitPattern(xmitPattern), .clkRatio(clkRatio), .bigEndian(bigEndian),
    .writeMode(writeMode), .timerIntOff(timerIntOff), .bus32(bus32),
    .driveLevel(driveLevel), .wrDelay(wrDelay), .fastMulEn(fastMulEn));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int expRatio(input logic [31:0] s);
    return (s[7:5] == 3'd7) ? 0 : int'(s[7:5]) + 2;
  endfunction

  function automatic int expDrive(input logic [31:0] s);
    case (s[14:13])
      2'b01: return 0;
      2'b00: return 1;
      2'b11: return 2;
      default: return 3;
    endcase
  endfunction

  function automatic bit expErr(input logic [31:0] s);
    return s[0] || (s[4:1] >= 4'd9) || (s[7:5] == 3'd7) || (s[10:9] == 2'b01)
           || s[18] || (s[31:20] != 0);
  endfunction

  function automatic logic [31:0] legalStream();
    logic [31:0] s;
    int wm;
    s = $urandom;
    s[0] = 1'b0;
    s[4:1] = 4'($urandom % 9);
    s[7:5] = 3'($urandom % 7);
    wm = $urandom % 3;
    s[10:9] = (wm == 0) ? 2'b00 : ((wm == 1) ? 2'b10 : 2'b11);
    s[18] = 1'b0;
    s[31:20] = '0;
    return s;
  endfunction

  task automatic checkFields(input logic [31:0] s);
    check(xmitPattern == s[4:1], "R4 pattern", xmitPattern, s[4:1]);
    check(clkRatio == 4'(expRatio(s)), "R5 ratio", clkRatio, expRatio(s));
    check(bigEndian == s[8], "R6 endian", bigEndian, s[8]);
    check(writeMode == s[10:9], "R6 writeMode", writeMode, s[10:9]);
    check(timerIntOff == s[11], "R6 timer", timerIntOff, s[11]);
    check(bus32 == s[12], "R6 bus32", bus32, s[12]);
    check(wrDelay == s[17:15], "R6 wrDelay", wrDelay, s[17:15]);
    check(fastMulEn == !s[19], "R6 fastMul", fastMulEn, !s[19]);
    check(driveLevel == 2'(expDrive(s)), "R7 drive", driveLevel, expDrive(s));
    check(cfgErr == expErr(s), "R8 error flag", cfgErr, expErr(s));
  endtask

  task automatic runStream(input logic [31:0] s);
    time t1, t2;
    int cnt;
    bit clkSeen;
    coldResetN = 1'b0;
    powerGood = 1'b0;
    modeIn = s[0];
    repeat (3) @(negedge clk);
    // R11: everything cleared while in reset
    check(!coreResetN && !cfgValid && !cfgErr && !modeClk && clkRatio == 0,
          "R11 reset state", {coreResetN, cfgValid, cfgErr, modeClk}, 0);
    coldResetN = 1'b1;
    clkSeen = 0;
    repeat (20) begin
      @(negedge clk);
      if (modeClk) clkSeen = 1;
    end
    // R3: nothing starts without power good
    check(!clkSeen && !cfgValid, "R3 idle before powerGood", clkSeen, 0);
    powerGood = 1'b1;
    t1 = 0;
    t2 = 0;
    for (int i = 1; i < LEN; i++) begin
      @(negedge modeClk);
      if (i == 1) t1 = $time;
      if (i == 2) t2 = $time;
      @(negedge clk);
      modeIn = s[i];
      if (i == LEN - 2) check(!cfgValid && clkRatio == 0, "R9 not early", cfgValid, 0);
    end
    check((t2 - t1) == DIV * 10, "R1 mode clock period", int'(t2 - t1), DIV * 10);
    while (!cfgValid) @(negedge clk);
    checkFields(s);
    cnt = 0;
    while (!coreResetN && cnt < 1000) begin
      @(negedge clk);
      cnt++;
    end
    check(cnt == HOLD, "R10 release delay", cnt, HOLD);
  endtask

  initial begin
    logic [31:0] s;
    logic [31:0] held;
    void'($urandom(32'd1234));
    modeIn = 1'b0;
    // random legal streams
    for (int k = 0; k < 6; k++) runStream(legalStream());
    // every drive encoding, and every ratio edge
    for (int d = 0; d < 4; d++) begin
      s = legalStream();
      s[14:13] = 2'(d);
      s[7:5] = (d == 0) ? 3'd0 : 3'd6;
      runStream(s);
    end
    // one reserved rule broken at a time (R8)
    s = legalStream(); s[0] = 1'b1;      runStream(s);
    s = legalStream(); s[4:1] = 4'd9;    runStream(s);
    s = legalStream(); s[4:1] = 4'd15;   runStream(s);
    s = legalStream(); s[7:5] = 3'd7;    runStream(s);
    s = legalStream(); s[10:9] = 2'b01;  runStream(s);
    s = legalStream(); s[18] = 1'b1;     runStream(s);
    s = legalStream(); s[31] = 1'b1;     runStream(s);
    // R11: abort a load partway, then reload
    coldResetN = 1'b0;
    repeat (2) @(negedge clk);
    coldResetN = 1'b1;
    powerGood = 1'b1;
    modeIn = 1'b1;
    repeat (DIV * 10) @(negedge clk);
    coldResetN = 1'b0;
    @(negedge clk);
    check(!cfgValid && !modeClk && !cfgErr, "R11 abort clears", cfgValid, 0);
    held = legalStream();
    runStream(held);
    // R9: later input activity ignored
    for (int c = 0; c < 300; c++) begin
      @(negedge clk);
      modeIn = 1'($urandom);
      powerGood = 1'($urandom);
      if (modeClk) check(0, "R1 mode clock idle after load", 1, 0);
    end
    checkFields(held);
    check(coreResetN && cfgValid, "R9 still released", coreResetN, 1);
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    testsRun++;
    testsFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFail);
    $finish;
  end

endmodule